// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block serves one CPU of an interrupt controller. It holds the set of interrupt sources currently raised toward that CPU (64 by default). Out of that set it presents the one to be taken next. Each source has a 5-bit priority supplied from outside. The winner is the raised source with the largest priority. When priorities are equal, the lowest source number wins. A source with priority 0 is still eligible.

The chosen source is held in a small cache. A full comparison runs only after the raised set has changed. Two events change it: any raise strobe, and an acknowledge that takes a source. Priority changes alone do not trigger a new comparison.

When the CPU acknowledges, the block does three things. It returns the vector of the chosen source, looked up outside through the presented index. It removes that source from the raised set. It then reselects. If nothing is selected at that moment, the acknowledge returns a fixed spurious vector and changes nothing.

Top module: `psel_cpu_selector`

## Requirements
- R1: After a synchronous active-low reset the raised set is empty, `irq_avail_o` and `ack_done_o` are 0, and `ack_vec_o` reads 0.
- R2: A 1 on bit n of `raise_i` at a clock edge adds source n to the raised set. The resulting selection is shown after the second edge from that raise.
- R3: Among raised sources, the one with the strictly greatest priority (`prio_i` bits [5n+4:5n] for source n) is selected. On equal priority the lowest source number is selected.
- R4: A raised source with priority 0 is selected when no other source is raised.
- R5: While no raise strobe and no acknowledge arrive, a valid selection (index and priority) stays unchanged, even if `prio_i` changes.
- R6: An acknowledge (`ack_i` high at an edge) while a selection is shown has these effects after that edge. `ack_done_o` is 1 for one cycle. `ack_vec_o` equals the `vec_i` presented for the selected index. The source leaves the raised set, and the selector reselects one edge later.
- R7: When the raised set is empty, `irq_avail_o` is 0.
- R8: An acknowledge while no selection is shown, including the cycle right after a raise, returns the spurious vector (default 8'hFF) on `ack_vec_o`. It leaves the raised set unchanged.
- R9: Raising a source already in the set keeps a single entry. A raise and an acknowledge of the same source at the same edge leave it raised.
- R10: In the cycle after any raise strobe, `irq_avail_o` is 0 while the new comparison runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_i | input | 64 | One raise strobe per source |
| prio_i | input | 320 | Priority of source n in bits [5n+4:5n] |
| irq_avail_o | output | 1 | A selection is valid and shown |
| sel_idx_o | output | 6 | Selected source number (0 when none) |
| sel_prio_o | output | 5 | Priority of the selected source (0 when none) |
| vec_i | input | 8 | Vector of the source at `sel_idx_o`, from an outside lookup |
| ack_i | input | 1 | Acknowledge strobe from the CPU |
| ack_done_o | output | 1 | One-cycle pulse after each acknowledge |
| ack_vec_o | output | 8 | Vector returned by the last acknowledge |

## Verification
The bench targets four corner cases:

- **Ties.** Equal priorities, including all-zero priorities, expose a design that keeps the last or highest index instead of the first.
- **Priority 0.** A lone priority-0 source catches a running best that starts at 0 rather than below it; such a design would report no interrupt.
- **Refresh-cycle acknowledge.** An acknowledge landing in the cycle right after a raise must give the spurious vector. A design that accepted it would clear a stale or wrong source.
- **Same-edge raise and acknowledge.** Raising and acknowledging one source at the same edge checks the set/clear ordering.

Priority edits without a raise check that the cache is not silently refreshed.

// File: rtl/psel_pkg.sv
// Package: default sizes and constants shared by the selector modules.
package psel_pkg;
    localparam int unsigned SRC_N_DEF  = 64;
    localparam int unsigned PRIO_W_DEF = 5;
    localparam int unsigned VEC_W_DEF  = 8;
    localparam logic [VEC_W_DEF-1:0] SPUR_VEC_DEF = 8'hFF;
endpackage

// File: rtl/psel_pick2.sv
// Module: psel_pick2
// Compares two candidates and passes on the winner. The "lo" input must
// carry the lower source numbers; "hi" wins only with a strictly greater
// priority, so ties keep the lower number.
// Assumes: each candidate's idx/prio are meaningful only when its valid is 1.
module psel_pick2 #(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned PRIO_W = 5
) (
    input  logic              lo_v,
    input  logic [IDX_W-1:0]  lo_idx,
    input  logic [PRIO_W-1:0] lo_prio,
    input  logic              hi_v,
    input  logic [IDX_W-1:0]  hi_idx,
    input  logic [PRIO_W-1:0] hi_prio,
    output logic              out_v,
    output logic [IDX_W-1:0]  out_idx,
    output logic [PRIO_W-1:0] out_prio
);
    logic take_hi;

    // choose the upper candidate only if it strictly beats the lower one
    always_comb begin
        take_hi  = hi_v && (!lo_v || (hi_prio > lo_prio));
        out_v    = lo_v | hi_v;
        out_idx  = take_hi ? hi_idx  : lo_idx;
        out_prio = take_hi ? hi_prio : lo_prio;
    end
endmodule

// File: rtl/psel_scan.sv
// Module: psel_scan
// Combinational priority scan over all sources, built as a balanced
// binary tree of psel_pick2 nodes in heap layout. Leaves sit in source
// order, left child always holds lower numbers, so the tree yields the
// lowest-numbered source among those with the greatest priority.
// Assumes: SRC_N is a power of two and at least 2.
module psel_scan #(
    parameter int unsigned SRC_N  = psel_pkg::SRC_N_DEF,
    parameter int unsigned PRIO_W = psel_pkg::PRIO_W_DEF,
    localparam int unsigned IDX_W = $clog2(SRC_N)
) (
    input  logic [SRC_N-1:0]        req,
    input  logic [SRC_N*PRIO_W-1:0] prio_flat,
    output logic                    found,
    output logic [IDX_W-1:0]        best_idx,
    output logic [PRIO_W-1:0]       best_prio
);
    localparam int unsigned NODES = 2 * SRC_N - 1;
    localparam int unsigned LEAF0 = SRC_N - 1;

    logic              nv [NODES];
    logic [IDX_W-1:0]  ni [NODES];
    logic [PRIO_W-1:0] np [NODES];

    genvar g;
    // leaves: one per source, carrying its request, number and priority
    for (g = 0; g < SRC_N; g++) begin : g_leaf
        assign nv[LEAF0+g] = req[g];
        assign ni[LEAF0+g] = IDX_W'(g);
        assign np[LEAF0+g] = prio_flat[g*PRIO_W +: PRIO_W];
    end

    // inner nodes: node k merges children 2k+1 (lower) and 2k+2 (upper)
    for (g = 0; g < SRC_N - 1; g++) begin : g_node
        psel_pick2 #(.IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_pick (
            .lo_v    (nv[2*g+1]),
            .lo_idx  (ni[2*g+1]),
            .lo_prio (np[2*g+1]),
            .hi_v    (nv[2*g+2]),
            .hi_idx  (ni[2*g+2]),
            .hi_prio (np[2*g+2]),
            .out_v   (nv[g]),
            .out_idx (ni[g]),
            .out_prio(np[g])
        );
    end

    assign found     = nv[0];
    assign best_idx  = ni[0];
    assign best_prio = np[0];
endmodule

// File: rtl/psel_raised_set.sv
// Module: psel_raised_set
// Holds the set of raised sources for one CPU. Raise strobes set bits;
// a single clear request removes one bit. A raise of the same bit at the
// same edge wins over the clear.
// Assumes: clr_idx is in range whenever clr_en is 1.
module psel_raised_set #(
    parameter int unsigned SRC_N = psel_pkg::SRC_N_DEF,
    localparam int unsigned IDX_W = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] raise,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [SRC_N-1:0] raised
);
    logic [SRC_N-1:0] raised_q;
    logic [SRC_N-1:0] clr_mask;

    // one-hot mask of the bit being removed
    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask[clr_idx] = 1'b1;
    end

    // update: clear first, then merge new raises
    always_ff @(posedge clk) begin
        if (!rst_n) raised_q <= '0;
        else        raised_q <= (raised_q & ~clr_mask) | raise;
    end

    assign raised = raised_q;
endmodule

// File: rtl/psel_sel_cache.sv
// Module: psel_sel_cache
// Caches the scan result and handles the acknowledge. The cache is dropped
// on any raise or on an accepted acknowledge, and reloaded from the scan
// on the following edge. An acknowledge is accepted only while a valid
// selection is shown; otherwise it returns the spurious vector.
// Assumes: vec_i is the vector of the source shown on sel_idx.
module psel_sel_cache #(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned PRIO_W = psel_pkg::PRIO_W_DEF,
    parameter int unsigned VEC_W  = psel_pkg::VEC_W_DEF,
    parameter logic [VEC_W-1:0] SPUR_VEC = psel_pkg::SPUR_VEC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_raise,
    input  logic              ack,
    input  logic              scan_found,
    input  logic [IDX_W-1:0]  scan_idx,
    input  logic [PRIO_W-1:0] scan_prio,
    input  logic [VEC_W-1:0]  vec_i,
    output logic              avail,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [PRIO_W-1:0] sel_prio,
    output logic              clr_en,
    output logic              ack_done,
    output logic [VEC_W-1:0]  ack_vec
);
    logic              ok_q;
    logic              found_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PRIO_W-1:0] prio_q;
    logic              done_q;
    logic [VEC_W-1:0]  vec_q;
    logic              shown;

    // a selection is shown only when the cache is loaded and found one
    assign shown  = ok_q & found_q;
    assign clr_en = ack & shown;

    // cache state: drop on change, reload from the scan when dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q    <= 1'b0;
            found_q <= 1'b0;
            idx_q   <= '0;
            prio_q  <= '0;
        end else if (any_raise || clr_en) begin
            ok_q    <= 1'b0;
            found_q <= 1'b0;
        end else if (!ok_q) begin
            ok_q    <= 1'b1;
            found_q <= scan_found;
            idx_q   <= scan_idx;
            prio_q  <= scan_prio;
        end
    end

    // acknowledge response: pulse plus the returned vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            done_q <= ack;
            if (ack) vec_q <= shown ? vec_i : SPUR_VEC;
        end
    end

    assign avail    = shown;
    assign sel_idx  = shown ? idx_q  : '0;
    assign sel_prio = shown ? prio_q : '0;
    assign ack_done = done_q;
    assign ack_vec  = vec_q;
endmodule

// File: rtl/psel_cpu_selector.sv
// Module: psel_cpu_selector (top)
// Per-CPU interrupt selector: raised set, cached priority scan and
// acknowledge handling. The vector is looked up outside from sel_idx_o.
// Assumes: SRC_N is a power of two; prio_i is held while a rescan runs.
module psel_cpu_selector #(
    parameter int unsigned SRC_N  = psel_pkg::SRC_N_DEF,
    parameter int unsigned PRIO_W = psel_pkg::PRIO_W_DEF,
    parameter int unsigned VEC_W  = psel_pkg::VEC_W_DEF,
    parameter logic [VEC_W-1:0] SPUR_VEC = psel_pkg::SPUR_VEC_DEF,
    localparam int unsigned IDX_W = $clog2(SRC_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_N-1:0]        raise_i,
    input  logic [SRC_N*PRIO_W-1:0] prio_i,
    output logic                    irq_avail_o,
    output logic [IDX_W-1:0]        sel_idx_o,
    output logic [PRIO_W-1:0]       sel_prio_o,
    input  logic [VEC_W-1:0]        vec_i,
    input  logic                    ack_i,
    output logic                    ack_done_o,
    output logic [VEC_W-1:0]        ack_vec_o
);
    logic [SRC_N-1:0]  raised_q;
    logic              clr_en;
    logic              scan_found;
    logic [IDX_W-1:0]  scan_idx;
    logic [PRIO_W-1:0] scan_prio;

    psel_raised_set #(.SRC_N(SRC_N)) u_set (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise  (raise_i),
        .clr_en (clr_en),
        .clr_idx(sel_idx_o),
        .raised (raised_q)
    );

    psel_scan #(.SRC_N(SRC_N), .PRIO_W(PRIO_W)) u_scan (
        .req      (raised_q),
        .prio_flat(prio_i),
        .found    (scan_found),
        .best_idx (scan_idx),
        .best_prio(scan_prio)
    );

    psel_sel_cache #(
        .IDX_W(IDX_W), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)
    ) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_raise (|raise_i),
        .ack       (ack_i),
        .scan_found(scan_found),
        .scan_idx  (scan_idx),
        .scan_prio (scan_prio),
        .vec_i     (vec_i),
        .avail     (irq_avail_o),
        .sel_idx   (sel_idx_o),
        .sel_prio  (sel_prio_o),
        .clr_en    (clr_en),
        .ack_done  (ack_done_o),
        .ack_vec   (ack_vec_o)
    );
endmodule

// File: rtl/psel_cpu_selector_chk.sv
// Module: psel_cpu_selector_chk
// Property checker for psel_cpu_selector, attached with bind below.
// Assumes: it sees the top's ports plus the internal raised set.
module psel_cpu_selector_chk #(
    parameter int unsigned SRC_N  = 64,
    parameter int unsigned PRIO_W = 5,
    parameter int unsigned VEC_W  = 8,
    parameter logic [VEC_W-1:0] SPUR_VEC = 8'hFF,
    localparam int unsigned IDX_W = $clog2(SRC_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  raise_i,
    input logic              irq_avail_o,
    input logic [IDX_W-1:0]  sel_idx_o,
    input logic [PRIO_W-1:0] sel_prio_o,
    input logic              ack_i,
    input logic              ack_done_o,
    input logic [VEC_W-1:0]  ack_vec_o,
    input logic [SRC_N-1:0]  raised_q
);
    // R3: a shown selection always names a raised source
    p_sel_is_raised_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_avail_o |-> raised_q[sel_idx_o]);

    // R7: nothing raised means nothing available
    p_empty_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raised_q == '0) |-> !irq_avail_o);

    // R10: a raise drops the shown selection for one cycle
    p_raise_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|raise_i) |=> !irq_avail_o);

    // R5: without raise or acknowledge the selection holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_avail_o && !(|raise_i) && !ack_i)
        |=> (irq_avail_o && $stable(sel_idx_o) && $stable(sel_prio_o)));

    // R6: an accepted acknowledge removes the selected source
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_avail_o && ack_i && !raise_i[sel_idx_o])
        |=> (!raised_q[$past(sel_idx_o)] && ack_done_o));

    // R6: every acknowledge gives a done pulse one edge later
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> ack_done_o);

    // R8: an acknowledge without a selection is spurious and changes no state
    p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_avail_o)
        |=> ((ack_vec_o == SPUR_VEC) && (raised_q == ($past(raised_q) | $past(raise_i)))));
endmodule

bind psel_cpu_selector psel_cpu_selector_chk #(
    .SRC_N(SRC_N), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise_i    (raise_i),
    .irq_avail_o(irq_avail_o),
    .sel_idx_o  (sel_idx_o),
    .sel_prio_o (sel_prio_o),
    .ack_i      (ack_i),
    .ack_done_o (ack_done_o),
    .ack_vec_o  (ack_vec_o),
    .raised_q   (raised_q)
);

// File: tb/sim_psel_cpu_selector.sv
// Bench for psel_cpu_selector: directed corner cases plus seeded random
// raise/acknowledge traffic, checked against a bench-side selection model.
module sim_psel_cpu_selector;
    localparam int N = 64;
    localparam int PW = 5;
    localparam logic [7:0] SPUR = 8'hFF;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  raise_i;
    logic [N*PW-1:0] prio_i;
    logic          irq_avail_o;
    logic [5:0]    sel_idx_o;
    logic [4:0]    sel_prio_o;
    logic [7:0]    vec_i;
    logic          ack_i;
    logic          ack_done_o;
    logic [7:0]    ack_vec_o;

    logic [4:0]    pr [N];
    logic [N-1:0]  m_raised;
    int            n_tests = 0;
    int            n_fail  = 0;
    bit            finished = 0;

    always #5 clk = ~clk;

    // outside vector lookup: vector = {2'b01, source number}
    assign vec_i = {2'b01, sel_idx_o};

    always_comb begin
        for (int i = 0; i < N; i++) prio_i[i*PW +: PW] = pr[i];
    end

    psel_cpu_selector u0 (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .prio_i(prio_i),
        .irq_avail_o(irq_avail_o), .sel_idx_o(sel_idx_o),
        .sel_prio_o(sel_prio_o), .vec_i(vec_i), .ack_i(ack_i),
        .ack_done_o(ack_done_o), .ack_vec_o(ack_vec_o)
    );

    // model: strict greater-than scan in ascending order, -1 when empty
    function automatic int exp_idx();
        int best = -1;
        int bp = -1;
        for (int i = 0; i < N; i++)
            if (m_raised[i] && int'(pr[i]) > bp) begin
                best = i;
                bp = int'(pr[i]);
            end
        return best;
    endfunction

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check_sel(input string req);
        int e = exp_idx();
        if (e < 0) begin
            chk(req, irq_avail_o == 1'b0, int'(irq_avail_o), 0);
        end else begin
            chk(req, irq_avail_o == 1'b1, int'(irq_avail_o), 1);
            chk(req, int'(sel_idx_o) == e, int'(sel_idx_o), e);
            chk(req, sel_prio_o == pr[e], int'(sel_prio_o), int'(pr[e]));
        end
    endtask

    // R2/R10: raise a mask, expect no selection for one cycle, then the model's
    task automatic do_raise(input logic [N-1:0] mask, input string req);
        raise_i = mask;
        step();
        raise_i = '0;
        m_raised |= mask;
        chk("R10", irq_avail_o == 1'b0, int'(irq_avail_o), 0);
        step();
        check_sel(req);
    endtask

    // R6/R8: acknowledge against the current selection
    task automatic do_ack(input string req);
        int e = exp_idx();
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
        chk("R6", ack_done_o == 1'b1, int'(ack_done_o), 1);
        if (e < 0) begin
            chk("R8", ack_vec_o == SPUR, int'(ack_vec_o), int'(SPUR));
        end else begin
            chk(req, ack_vec_o == {2'b01, 6'(e)}, int'(ack_vec_o), 64 + e);
            m_raised[e] = 1'b0;
            chk("R6", irq_avail_o == 1'b0, int'(irq_avail_o), 0);
        end
        step();
        chk("R6", ack_done_o == 1'b0, int'(ack_done_o), 0);
        check_sel(req);
    endtask

    initial begin : stim
        int unsigned seed_dummy;
        int held_idx;
        int x;
        seed_dummy = $urandom(32'h5EED1234);
        rst_n = 1'b0; raise_i = '0; ack_i = 1'b0; m_raised = '0;
        for (int i = 0; i < N; i++) pr[i] = 5'd0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1", irq_avail_o == 1'b0, int'(irq_avail_o), 0);
        chk("R1", ack_done_o == 1'b0, int'(ack_done_o), 0);
        chk("R1", ack_vec_o == 8'h00, int'(ack_vec_o), 0);
        // R7: stays empty; R8: acknowledge on empty set is spurious
        repeat (2) step();
        check_sel("R7");
        do_ack("R8");
        // R4: lone priority-0 source is selected
        do_raise(64'h1 << 40, "R4");
        // R3: tie at priority 0, lower number wins
        do_raise(64'h1 << 10, "R3");
        // R3: strictly greater priority wins, equal one loses to lower number
        pr[50] = 5'd7;
        do_raise(64'h1 << 50, "R3");
        pr[5] = 5'd7;
        do_raise(64'h1 << 5, "R3");
        chk("R3", sel_idx_o == 6'd5, int'(sel_idx_o), 5);
        // R5: priority edit without raise keeps the cached choice
        held_idx = int'(sel_idx_o);
        pr[40] = 5'd31;
        repeat (4) step();
        chk("R5", irq_avail_o == 1'b1, int'(irq_avail_o), 1);
        chk("R5", int'(sel_idx_o) == held_idx, int'(sel_idx_o), held_idx);
        chk("R5", sel_prio_o == 5'd7, int'(sel_prio_o), 7);
        // R9: re-raising a raised source rescans, now source 40 wins
        do_raise(64'h1 << 40, "R9");
        // R6: acknowledge 40, then 5 is next
        do_ack("R6");
        do_ack("R6");
        // R9: only a single entry for 40 existed; it is gone
        chk("R9", sel_idx_o == 6'd50, int'(sel_idx_o), 50);
        // R8: acknowledge in the refresh cycle right after a raise
        pr[60] = 5'd1;
        raise_i = 64'h1 << 60;
        step();
        raise_i = '0;
        m_raised[60] = 1'b1;
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
        chk("R8", ack_vec_o == SPUR, int'(ack_vec_o), int'(SPUR));
        check_sel("R8");
        // R9: raise and acknowledge of the same source at one edge
        x = int'(sel_idx_o);
        raise_i = 64'h1 << x;
        ack_i = 1'b1;
        step();
        raise_i = '0; ack_i = 1'b0;
        chk("R9", ack_vec_o == {2'b01, 6'(x)}, int'(ack_vec_o), 64 + x);
        step();
        check_sel("R9");
        chk("R9", int'(sel_idx_o) == x, int'(sel_idx_o), x);
        // random traffic: raises with fresh priorities, acknowledges
        for (int it = 0; it < 400; it++) begin
            if (($urandom % 3) != 0) begin
                logic [N-1:0] mask = '0;
                int k = 1 + ($urandom % 3);
                for (int j = 0; j < k; j++) begin
                    int s = $urandom % N;
                    mask[s] = 1'b1;
                    if (!m_raised[s])
                        pr[s] = (($urandom % 2) != 0) ? 5'($urandom % 4) : 5'($urandom);
                end
                do_raise(mask, "R3");
            end else begin
                do_ack("R6");
            end
        end
        // drain: acknowledge until empty, then one spurious
        for (int d = 0; d < N + 1; d++) do_ack("R6");
        check_sel("R7");
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule